// File: doc/BRIEF.md
# Satellite Equipment Control Tone Sequencer

This block drives the tone line used to command outdoor satellite equipment. A host loads up to six message bytes into a small buffer, picks a mode (full message or single tone burst) and then writes a command word. The block produces a tone envelope (`tone_gate`) and the gated 22 kHz square wave (`tone_wave`). It also holds a continuous-tone enable and a supply-voltage select (`volt_sel`). The host polls `ready` to learn when the next command may be issued.

A message is sent most significant bit first. Each byte is followed by an odd-parity bit. Every symbol is three time units long, and one unit is `UNIT_CYC` clocks (0.5 ms on silicon). A zero symbol is two units of tone and then one unit of silence. A one symbol is one unit of tone and then two units of silence. An unmodulated burst is 25 units of tone. A modulated burst is eight one-symbols with no parity bit. Every transmission ends with 30 units of silence before `ready` returns.

Top module: `dsq_ctrl`

## Requirements
- R1: After reset, `ready`=1, `tone_gate`=0, `tone_wave`=0 and `volt_sel`=0.
- R2: A write to the command address 0x29 with bit 6 clear is a configuration write. It takes `volt_sel` from bit 7 (1 = 13 V, 0 = 18 V) and the continuous-tone enable from bit 4. `volt_sel` changes at the write edge. While the tone is enabled and the block is idle, `tone_gate` is 1, starting one cycle after the write edge.
- R3: A write to 0x29 with bit 6 set is a launch write. It leaves the stored voltage select and tone enable unchanged, whatever the written bits 7 and 4 are. Its bits [1:0] give the message length minus 3, so code 0 means 3 bytes and code 3 means 6 bytes.
- R4: A launch while the continuous tone is enabled is refused. `ready` stays 1 and `tone_gate` stays 1.
- R5: Message byte i is written at address 0x2C+i. It is sent bit 7 first, followed by an odd-parity bit, so that the nine bits hold an odd number of ones. A zero symbol has a tone run of 2 units, and a one symbol has a tone run of 1 unit.
- R6: A mode register at 0x2A selects tone-burst mode when its low 3 bits equal 4. Any other value selects message mode. In burst mode, launch bit 3 clear gives one tone run of 25 units. Launch bit 3 set gives eight 1-unit tone runs.
- R7: `ready` falls at the launch edge and stays 0 for exactly (symbols×3+30)×`UNIT_CYC` cycles. For burst A this is 55×`UNIT_CYC` cycles. `tone_gate` is 0 when `ready` returns.
- R8: While `ready`=0, writes to the command, mode and message addresses have no effect.
- R9: `tone_wave` equals `tone_gate` ANDed with a free-running square wave that toggles every `TONE_HALF` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| ready | output | 1 | High when a new command is accepted |
| tone_gate | output | 1 | Tone envelope |
| tone_wave | output | 1 | Gated 22 kHz square wave |
| volt_sel | output | 1 | Supply voltage select, 1 = 13 V |

## Verification
`ready` and `volt_sel` respond at the write edge itself, so the bench reads them at the falling edge right after the write. `tone_gate` passes through one more register and trails the sequencer by one cycle. The bench therefore checks a continuous-tone change one falling edge later. For transmissions, the bench samples at every falling edge from the launch until `ready` rises. It counts the busy cycles and records the length of each tone run. It then compares both against the durations it derives from the symbol rules, which do not depend on that one-cycle lag.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_BURSTA, ST_GAP} seq_st_t;
  localparam int BURSTA_UNITS = 25;
  localparam int GAP_UNITS    = 30;
  localparam int SYM_UNITS    = 3;
  localparam int MAX_BYTES    = 6;
  localparam logic [7:0] A_CMD  = 8'h29;
  localparam logic [7:0] A_MODE = 8'h2A;
  localparam logic [7:0] A_MSG0 = 8'h2C;
  localparam logic [2:0] MODE_BURST = 3'd4;
endpackage

// File: rtl/dsq_tone_div.sv
module dsq_tone_div #(
  parameter int TONE_HALF = 1136
) (
  input  logic clk,
  input  logic rst,
  output logic sq
);
  localparam int W = (TONE_HALF > 1) ? $clog2(TONE_HALF) : 1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (cnt == W'(TONE_HALF - 1)) begin
      cnt <= '0;
      sq  <= ~sq;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < TONE_HALF); // R9
endmodule

// File: rtl/dsq_seq.sv
module dsq_seq
  import dsq_pkg::*;
#(
  parameter int UNIT_CYC = 25000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       launch,
  input  logic       burst,
  input  logic       burst_b,
  input  logic [1:0] len_code,
  output logic [2:0] rd_idx,
  input  logic [7:0] rd_byte,
  output logic       busy,
  output logic       env
);
  localparam int CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;

  seq_st_t      st;
  logic [CW-1:0] cyc;
  logic [4:0]   unit;
  logic [3:0]   bitpos;
  logic [2:0]   byte_i;
  logic [2:0]   last_i;
  logic         bb;
  logic         cur_bit;
  logic         unit_end;

  assign unit_end = (cyc == CW'(UNIT_CYC - 1));
  assign rd_idx   = byte_i;
  assign busy     = (st != ST_IDLE);

  always_comb begin
    if (bb)               cur_bit = 1'b1;
    else if (bitpos == 4'd8) cur_bit = ~^rd_byte;
    else                  cur_bit = rd_byte[3'(4'd7 - bitpos)];
  end

  always_comb begin
    case (st)
      ST_BITS:   env = (unit == 5'd0) || ((unit == 5'd1) && !cur_bit);
      ST_BURSTA: env = 1'b1;
      default:   env = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      cyc <= '0;
      unit <= '0;
      bitpos <= '0;
      byte_i <= '0;
      last_i <= '0;
      bb <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (launch) begin
        cyc <= '0;
        unit <= '0;
        bitpos <= '0;
        byte_i <= '0;
        last_i <= 3'(len_code) + 3'd2;
        bb <= burst && burst_b;
        st <= (burst && !burst_b) ? ST_BURSTA : ST_BITS;
      end
    end else if (!unit_end) begin
      cyc <= cyc + 1'b1;
    end else begin
      cyc <= '0;
      case (st)
        ST_BITS: begin
          if (unit != 5'(SYM_UNITS - 1)) begin
            unit <= unit + 1'b1;
          end else begin
            unit <= '0;
            if (bb) begin
              if (bitpos == 4'd7) st <= ST_GAP;
              else bitpos <= bitpos + 1'b1;
            end else if (bitpos == 4'd8) begin
              bitpos <= '0;
              if (byte_i == last_i) st <= ST_GAP;
              else byte_i <= byte_i + 1'b1;
            end else begin
              bitpos <= bitpos + 1'b1;
            end
          end
        end
        ST_BURSTA: begin
          if (unit == 5'(BURSTA_UNITS - 1)) begin
            unit <= '0;
            st <= ST_GAP;
          end else unit <= unit + 1'b1;
        end
        default: begin
          if (unit == 5'(GAP_UNITS - 1)) begin
            unit <= '0;
            st <= ST_IDLE;
          end else unit <= unit + 1'b1;
        end
      endcase
    end
  end

  AST_SYM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (bitpos <= 4'd8) && (byte_i <= last_i) && (32'(byte_i) < MAX_BYTES)); // R5
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    launch |-> !busy); // R8
endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int UNIT_CYC  = 25000,
  parameter int TONE_HALF = 1136
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       ready,
  output logic       tone_gate,
  output logic       tone_wave,
  output logic       volt_sel
);
  logic [7:0] msg_mem [MAX_BYTES];
  logic [2:0] mode_q;
  logic       tone_q;
  logic       gate_q;
  logic       busy;
  logic       env;
  logic       sq;
  logic [2:0] rd_idx;
  logic [7:0] msg_off;
  logic       hit_cmd;
  logic       launch;
  logic       msg_hit;

  assign hit_cmd = wr_en && (wr_addr == A_CMD) && !busy;
  assign launch  = hit_cmd && wr_data[6] && !tone_q;
  assign msg_off = wr_addr - A_MSG0;
  assign msg_hit = wr_en && !busy && (wr_addr >= A_MSG0) &&
                   (32'(msg_off) < MAX_BYTES);

  always_ff @(posedge clk) begin
    if (msg_hit) msg_mem[msg_off[2:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      tone_q   <= 1'b0;
      volt_sel <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      if (wr_en && !busy && (wr_addr == A_MODE)) mode_q <= wr_data[2:0];
      if (hit_cmd && !wr_data[6]) begin
        volt_sel <= wr_data[7];
        tone_q   <= wr_data[4];
      end
      gate_q <= env || (tone_q && !busy);
    end
  end

  dsq_seq #(.UNIT_CYC(UNIT_CYC)) u_seq (
    .clk(clk), .rst(rst), .launch(launch),
    .burst(mode_q == MODE_BURST), .burst_b(wr_data[3]),
    .len_code(wr_data[1:0]), .rd_idx(rd_idx), .rd_byte(msg_mem[rd_idx]),
    .busy(busy), .env(env)
  );

  dsq_tone_div #(.TONE_HALF(TONE_HALF)) u_div (
    .clk(clk), .rst(rst), .sq(sq)
  );

  assign ready     = !busy;
  assign tone_gate = gate_q;
  assign tone_wave = gate_q && sq;

  AST_READY_FALL: assert property (@(posedge clk) disable iff (rst)
    launch |=> !ready); // R7
  AST_TONE_REFUSE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tone_q); // R4
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(volt_sel) && $stable(tone_q)); // R8
endmodule

// File: tb/tb_dsq_ctrl.sv
module tb_dsq_ctrl;
  localparam int U = 8;
  localparam int TH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ready, tone_gate, tone_wave, volt_sel;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int runs [64];
  int nruns;
  int busy_cnt;
  int exp_runs [64];
  int nexp;
  logic [7:0] mb [6];

  always #5 clk = ~clk;

  dsq_ctrl #(.UNIT_CYC(U), .TONE_HALF(TH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready(ready), .tone_gate(tone_gate), .tone_wave(tone_wave), .volt_sel(volt_sel)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic capture();
    int run = 0;
    nruns = 0; busy_cnt = 0;
    while (!ready) begin
      busy_cnt = busy_cnt + 1;
      if (tone_gate) run = run + 1;
      else if (run > 0) begin
        if (nruns < 64) runs[nruns] = run;
        nruns = nruns + 1; run = 0;
      end
      @(negedge clk);
    end
    if (run > 0) begin
      if (nruns < 64) runs[nruns] = run;
      nruns = nruns + 1;
    end
    chk(tone_gate == 1'b0, "R7 silent at ready", int'(tone_gate), 0);
  endtask

  function automatic void build_msg(input int nb);
    nexp = 0;
    for (int b = 0; b < nb; b++) begin
      for (int k = 7; k >= 0; k--) begin
        exp_runs[nexp] = mb[b][k] ? U : 2 * U; nexp++;
      end
      exp_runs[nexp] = (^mb[b]) ? 2 * U : U; nexp++;
    end
  endfunction

  task automatic compare(input string req, input int exp_busy);
    int bad = 0;
    chk(busy_cnt == exp_busy, {req, " busy length"}, busy_cnt, exp_busy);
    chk(nruns == nexp, {req, " tone run count"}, nruns, nexp);
    for (int i = 0; i < nexp && i < nruns; i++)
      if (runs[i] != exp_runs[i]) begin
        if (bad == 0) chk(1'b0, {req, " run length"}, runs[i], exp_runs[i]);
        bad++;
      end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  task automatic send_msg(input int nb, input logic [7:0] cmd_hi, input string req);
    for (int i = 0; i < nb; i++) wr(8'h2C + 8'(i), mb[i]);
    wr(8'h29, cmd_hi | 8'h40 | 8'(nb - 3));
    build_msg(nb);
    capture();
    compare(req, (nb * 27 + 30) * U);
  endtask

  initial begin
    int toggles;
    logic prev;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(tone_gate == 1'b0, "R1 tone_gate", int'(tone_gate), 0);
    chk(tone_wave == 1'b0, "R1 tone_wave", int'(tone_wave), 0);
    chk(volt_sel == 1'b0, "R1 volt_sel", int'(volt_sel), 0);

    wr(8'h29, 8'h80);
    chk(volt_sel == 1'b1, "R2 volt 13V", int'(volt_sel), 1);
    wr(8'h29, 8'h10);
    chk(volt_sel == 1'b0, "R2 volt 18V", int'(volt_sel), 0);
    @(negedge clk);
    chk(tone_gate == 1'b1, "R2 continuous tone", int'(tone_gate), 1);
    repeat (3) @(negedge clk);
    toggles = 0; prev = tone_wave;
    for (int i = 0; i < 10 * TH; i++) begin
      @(negedge clk);
      if (tone_wave != prev) toggles++;
      prev = tone_wave;
    end
    chk(toggles == 10, "R9 square wave toggles", toggles, 10);

    wr(8'h29, 8'h40);
    chk(ready == 1'b1, "R4 refused launch ready", int'(ready), 1);
    repeat (5) @(negedge clk);
    chk(ready == 1'b1 && tone_gate == 1'b1, "R4 tone kept", int'(tone_gate), 1);

    wr(8'h29, 8'h00);
    @(negedge clk);
    chk(tone_gate == 1'b0, "R2 tone off", int'(tone_gate), 0);
    toggles = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tone_wave) toggles++;
    end
    chk(toggles == 0, "R9 wave gated off", toggles, 0);

    wr(8'h2A, 8'h00);
    mb[0] = 8'h00; mb[1] = 8'hFF; mb[2] = 8'h01;
    send_msg(3, 8'h00, "R5 parity directed");

    wr(8'h29, 8'h80);
    for (int i = 0; i < 6; i++) mb[i] = 8'hA5 ^ 8'(i * 37);
    send_msg(6, 8'h10, "R3 six bytes");
    chk(volt_sel == 1'b1, "R3 volt preserved", int'(volt_sel), 1);
    @(negedge clk);
    chk(tone_gate == 1'b0, "R3 tone bit not taken", int'(tone_gate), 0);

    wr(8'h2A, 8'h04);
    wr(8'h29, 8'h40);
    nexp = 1; exp_runs[0] = 25 * U;
    capture();
    compare("R6 burst A", 55 * U);
    wr(8'h29, 8'h48);
    nexp = 8;
    for (int i = 0; i < 8; i++) exp_runs[i] = U;
    capture();
    compare("R6 burst B", 54 * U);

    wr(8'h29, 8'h40);
    wr(8'h29, 8'h10);
    wr(8'h2A, 8'h00);
    while (!ready) @(negedge clk);
    chk(volt_sel == 1'b1, "R8 volt unchanged", int'(volt_sel), 1);
    @(negedge clk);
    chk(tone_gate == 1'b0, "R8 tone not enabled", int'(tone_gate), 0);
    wr(8'h29, 8'h40);
    nexp = 1; exp_runs[0] = 25 * U;
    capture();
    compare("R8 mode kept burst", 55 * U);

    wr(8'h2A, 8'h01);
    for (int it = 0; it < 8; it++) begin
      int nb;
      nb = 3 + int'($urandom_range(0, 3));
      for (int i = 0; i < nb; i++) mb[i] = 8'($urandom_range(0, 255));
      send_msg(nb, 8'($urandom_range(0, 1)) << 7, "R5 R7 random message");
    end
    chk(volt_sel == 1'b1, "R3 volt after random", int'(volt_sel), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule